// File: doc/BRIEF.md
# External Interrupt Event Detector

This block watches a set of asynchronous interrupt pins (eight by default) and keeps one pending flag per pin. Three per-pin configuration bytes set what counts as an event on each pin. An edge-select bit chooses between edge and level detection. A polarity bit chooses rising or falling in edge mode, and high or low in level mode. A both-edge bit overrides the other two and makes any transition an event. Each pin first passes through a synchroniser clocked by the system clock.

Software reaches the block through a simple write port and a combinational read port. Four byte-wide locations are decoded: edge select, polarity, both-edge and the pending flags. A flag is cleared by writing 0 to its bit, and writing 1 to a bit leaves it as it is. A single interrupt request is raised whenever a pending flag meets its per-pin enable input. Priority and vectoring belong to the consumer of that request.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, the edge-select (address 0), polarity (address 1), both-edge (address 2) and flag (address 3) bytes all read 00h and `irq` is low, with the pins held high.
- R2: A write to address 0, 1 or 2 stores `wr_data` in that configuration byte, and `rd_data` returns the stored byte when `rd_addr` selects it.
- R3: With a pin's both-edge bit 0 and edge-select bit 1, polarity 1 sets the flag on a rising transition and polarity 0 sets it on a falling transition. The opposite transition has no effect on the flag.
- R4: With both-edge 0 and edge-select 0, the flag is set on every clock while the pin is at its active level (polarity 1 is high, polarity 0 is low). A clear written during that time does not stick. A clear written after the pin returns to its inactive level does stick.
- R5: With a pin's both-edge bit 1, a transition in either direction sets its flag, whatever its edge-select and polarity bits hold.
- R6: A write to address 3 clears every flag bit whose `wr_data` bit is 0 and leaves every flag bit whose `wr_data` bit is 1 unchanged.
- R7: When a detected event and a clearing write hit the same flag bit in the same cycle, the flag ends up set.
- R8: A pin change made between clock edges shows in the flag after the third rising edge that follows, and not after the second.
- R9: `irq` is high exactly when some flag bit is set and its `pin_en` bit is 1.
- R10: An event on one pin changes only that pin's flag bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous external interrupt pins |
| pin_en | input | NUM_PINS | Per-pin enable into the combined request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 edge select, 1 polarity, 2 both-edge, 3 flags) |
| wr_data | input | NUM_PINS | Write data |
| rd_addr | input | 2 | Read address, same decode as writes |
| rd_data | output | NUM_PINS | Read data, combinational from `rd_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
A pin change made at a falling clock edge passes two synchroniser flops and then the flag register. The bench therefore samples the flag byte just after the second rising edge, where it must still be clear, and again just after the third, where it must be set. Register writes land on the rising edge inside the write strobe, so read-back and clear results are sampled at the following falling edge. `irq` follows the flags combinationally, so it is sampled at the same moment as the flag it depends on. The clear-versus-set collision is arranged by asserting the clearing write exactly on the third edge after a pin change.

// File: rtl/eirq_pkg.sv
// Package: shared register decode for the external interrupt detector.
// Assumes a two-bit register address.
package eirq_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_EDGE = 2'd0,
        REG_POL  = 2'd1,
        REG_BOTH = 2'd2,
        REG_FLAG = 2'd3
    } eirq_reg_e;
endpackage

// File: rtl/eirq_sync.sv
// Module: per-pin multi-flop synchroniser.
// Assumes the pins are asynchronous to clk. RESET_VAL is loaded into every
// stage so that the first cycles after reset see a known pin level.
module eirq_sync #(
    parameter int NUM_PINS    = 8,
    parameter int STAGES      = 2,
    parameter bit RESET_VAL   = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_async,
    output logic [NUM_PINS-1:0] pin_sync
);
    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
            logic [STAGES-1:0] chain_q;

            // Shift the raw pin through the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], pin_async[g]};
            end

            assign pin_sync[g] = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/eirq_detect.sv
// Module: per-pin event detector.
// Compares the synchronised level with the previous cycle's value and
// applies the both-edge, edge-select and polarity choices. The output is
// combinational, one cycle ahead of the flag register.
module eirq_detect #(
    parameter int NUM_PINS  = 8,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_sync,
    input  logic [NUM_PINS-1:0] cfg_edge,
    input  logic [NUM_PINS-1:0] cfg_pol,
    input  logic [NUM_PINS-1:0] cfg_both,
    output logic [NUM_PINS-1:0] event_v
);
    logic [NUM_PINS-1:0] prev_q;

    // Hold last cycle's synchronised level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= {NUM_PINS{RESET_VAL}};
        else        prev_q <= pin_sync;
    end

    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_det
            logic rise, fall, lvl_hit, edge_hit;

            // Classify this pin's current sample against its configuration.
            always_comb begin
                rise     = pin_sync[g] & ~prev_q[g];
                fall     = ~pin_sync[g] & prev_q[g];
                lvl_hit  = cfg_pol[g] ? pin_sync[g] : ~pin_sync[g];
                edge_hit = cfg_pol[g] ? rise : fall;
                if (cfg_both[g])      event_v[g] = rise | fall;
                else if (cfg_edge[g]) event_v[g] = edge_hit;
                else                  event_v[g] = lvl_hit;
            end
        end
    endgenerate
endmodule

// File: rtl/eirq_regs.sv
// Module: configuration bytes, pending flags and read mux.
// Assumes one write per cycle; a hardware event beats a software clear.
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [NUM_PINS-1:0] wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic [NUM_PINS-1:0] event_v,
    output logic [NUM_PINS-1:0] cfg_edge,
    output logic [NUM_PINS-1:0] cfg_pol,
    output logic [NUM_PINS-1:0] cfg_both,
    output logic [NUM_PINS-1:0] flags,
    output logic [NUM_PINS-1:0] rd_data
);
    logic [NUM_PINS-1:0] keep_mask;

    // Bits that survive this cycle's software access to the flag byte.
    always_comb begin
        keep_mask = '1;
        if (wr_en && eirq_reg_e'(wr_addr) == REG_FLAG) keep_mask = wr_data;
    end

    // Configuration byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_edge <= '0;
            cfg_pol  <= '0;
            cfg_both <= '0;
        end else if (wr_en) begin
            case (eirq_reg_e'(wr_addr))
                REG_EDGE: cfg_edge <= wr_data;
                REG_POL:  cfg_pol  <= wr_data;
                REG_BOTH: cfg_both <= wr_data;
                default:  ;
            endcase
        end
    end

    // Pending flags: clear by writing zero, set on events, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & keep_mask) | event_v;
    end

    // Combinational read-back.
    always_comb begin
        case (eirq_reg_e'(rd_addr))
            REG_EDGE: rd_data = cfg_edge;
            REG_POL:  rd_data = cfg_pol;
            REG_BOTH: rd_data = cfg_both;
            default:  rd_data = flags;
        endcase
    end
endmodule

// File: rtl/ext_irq_detect.sv
// Module: top of the external interrupt detector.
// Synchronises the pins, detects configured events, keeps pending flags
// and ORs enabled flags into one request. Pins should idle high at reset.
module ext_irq_detect
    import eirq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] pin_en,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [NUM_PINS-1:0] wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [NUM_PINS-1:0] rd_data,
    output logic                irq
);
    localparam bit IDLE_LEVEL = 1'b1;

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] event_v;
    logic [NUM_PINS-1:0] cfg_edge, cfg_pol, cfg_both;
    logic [NUM_PINS-1:0] flag_q;

    eirq_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES), .RESET_VAL(IDLE_LEVEL)) i_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_in), .pin_sync(pin_sync)
    );

    eirq_detect #(.NUM_PINS(NUM_PINS), .RESET_VAL(IDLE_LEVEL)) i_detect (
        .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync),
        .cfg_edge(cfg_edge), .cfg_pol(cfg_pol), .cfg_both(cfg_both),
        .event_v(event_v)
    );

    eirq_regs #(.NUM_PINS(NUM_PINS)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .event_v(event_v),
        .cfg_edge(cfg_edge), .cfg_pol(cfg_pol), .cfg_both(cfg_both),
        .flags(flag_q), .rd_data(rd_data)
    );

    // Combined request from enabled pending flags.
    assign irq = |(flag_q & pin_en);
endmodule

// File: rtl/eirq_checker.sv
// Module: assertion checker for ext_irq_detect, attached by bind below.
module eirq_checker #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [1:0]          wr_addr,
    input logic [NUM_PINS-1:0] wr_data,
    input logic [NUM_PINS-1:0] pin_en,
    input logic                irq,
    input logic [NUM_PINS-1:0] flag_q,
    input logic [NUM_PINS-1:0] event_v,
    input logic [NUM_PINS-1:0] cfg_edge
);
    // R7: a detected event always leaves its flag set next cycle.
    a_r7_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (event_v != '0) |=> ((flag_q & $past(event_v)) == $past(event_v)));

    // R6: written zero bits with no event are cleared.
    a_r6_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> ((flag_q & ~$past(wr_data) & ~$past(event_v)) == '0));

    // R6: written one bits that were set stay set.
    a_r6_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> ((flag_q & $past(flag_q & wr_data)) == $past(flag_q & wr_data)));

    // R10: a flag only rises where an event was detected.
    a_r10_flag_rises_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(event_v)) == '0));

    // R2: the edge-select byte holds without a write to it.
    a_r2_config_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == 2'd0) |=> $stable(cfg_edge));

    // R9: a request needs an enabled pending flag.
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((flag_q & pin_en) != '0));
endmodule

bind ext_irq_detect eirq_checker #(.NUM_PINS(NUM_PINS)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pin_en(pin_en), .irq(irq), .flag_q(flag_q),
    .event_v(event_v), .cfg_edge(cfg_edge)
);

// File: tb/test_ext_irq_detect.sv
// Bench: sweeps every pin through all eight configuration combinations.
module test_ext_irq_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] pin_en = 8'h00;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    ext_irq_detect i_ext_irq_detect (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_en(pin_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wreg(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rreg(logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    // Sweep one pin through one configuration: activate, clear, return, clear.
    task automatic run_case(logic [2:0] mode, int p);
        logic both, edg, pol, idle, lvl;
        logic [7:0] v, one;
        both = mode[2]; edg = mode[1]; pol = mode[0];
        lvl  = !both && !edg;
        idle = both ? 1'b1 : ~pol;
        one  = 8'h01 << p;
        pin_en = 8'hA5 ^ {mode, mode, 2'b01};
        wreg(2'd0, {8{edg}});
        wreg(2'd1, {8{pol}});
        wreg(2'd2, {8{both}});
        @(negedge clk) pin_in = {8{idle}};
        repeat (4) @(posedge clk);
        wreg(2'd3, 8'h00);
        rreg(2'd3, v); check("R6 clear before case", v, 8'h00);
        pin_in[p] = ~idle;
        @(posedge clk); @(posedge clk); #2;
        rreg(2'd3, v); check("R8 not yet after two edges", v, 8'h00);
        @(posedge clk); #2;
        rreg(2'd3, v);
        check(both ? "R5 both-edge set" : (lvl ? "R4 level set" : "R3 edge set"), v, one);
        check("R10 only own pin", v & ~one, 8'h00);
        check("R9 irq follows enable", {7'd0, irq}, {7'd0, pin_en[p]});
        wreg(2'd3, 8'hFF);
        rreg(2'd3, v); check("R6 write one keeps", v, one);
        wreg(2'd3, 8'h00);
        rreg(2'd3, v); check(lvl ? "R4 clear does not stick" : "R6 zero clears", v, lvl ? one : 8'h00);
        @(negedge clk) pin_in[p] = idle;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rreg(2'd3, v);
        check(both ? "R5 return edge sets" : (lvl ? "R4 flag held" : "R3 opposite edge ignored"),
              v, (both || lvl) ? one : 8'h00);
        wreg(2'd3, 8'h00);
        rreg(2'd3, v); check("R4 clear sticks when inactive", v, 8'h00);
    endtask

    initial begin
        #(20 * 200000);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rreg(a[1:0], v); check("R1 reset value", v, 8'h00);
        end
        pin_en = 8'hFF; #1;
        check("R1 irq low after reset", {7'd0, irq}, 8'h00);
        // R2 read-back of distinct patterns
        wreg(2'd0, 8'h3C); wreg(2'd1, 8'h5A); wreg(2'd2, 8'h81);
        rreg(2'd0, v); check("R2 edge byte", v, 8'h3C);
        rreg(2'd1, v); check("R2 polarity byte", v, 8'h5A);
        rreg(2'd2, v); check("R2 both byte", v, 8'h81);
        // Full sweep of modes and pins
        for (int m = 0; m < 8; m++)
            for (int p = 0; p < 8; p++)
                run_case(m[2:0], p);
        // R7 set beats same-cycle clear on rising edge of pin 0
        wreg(2'd0, 8'hFF); wreg(2'd1, 8'hFF); wreg(2'd2, 8'h00);
        @(negedge clk) pin_in = 8'h00;
        repeat (4) @(posedge clk);
        wreg(2'd3, 8'h00);
        pin_in[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk) begin wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h00; end
        @(posedge clk); #2;
        rreg(2'd3, v); check("R7 set wins over clear", v, 8'h01);
        @(negedge clk) wr_en = 1'b0;
        pin_en = 8'h00; #1;
        check("R9 irq low with no enables", {7'd0, irq}, 8'h00);
        finish_run();
    end
endmodule